// File: doc/BRIEF.md
# Chip-Select Idle Timeout Counter

This block decides how long the external memory chip-select stays asserted once a memory-mapped access has happened. Every access strobe from the access engine asserts the chip-select hold output and restarts an idle count. While no further access arrives, the block counts clock cycles. When the count reaches a programmable 16-bit limit, the block releases chip-select. In the same edge it sets a sticky timeout flag, which can also drive an interrupt line.

The counter acts only while the functional-mode input selects memory-mapped operation and the peripheral is enabled. Any other mode, a cleared peripheral enable, or an abort request releases chip-select and zeroes the count. An abort is acknowledged by a one-cycle done pulse. With the counter disabled, chip-select is held for as long as the block stays in memory-mapped mode.

Top module: `cs_idle_timer`

## Requirements
- R1: While reset is asserted and after it, until the first stimulus, cs_hold, tmo_flag, tmo_irq and abort_done are all 0.
- R2: With func_mode = 2'b11 and periph_en = 1, an access_pulse sampled at an edge sets cs_hold to 1 after that edge and restarts the idle count at zero. An access in the cycle where the limit would be reached wins, so chip-select stays held.
- R3: With tmo_en = 1 and tmo_limit = L (L >= 1), cs_hold stays 1 for exactly L idle edges after the access edge and falls on the L-th idle edge. L = 0 behaves as L = 1.
- R4: With tmo_en = 0, cs_hold stays 1 after a memory-mapped access for any number of idle cycles, and tmo_flag is not set.
- R5: With func_mode other than 2'b11, cs_hold is 0, access_pulse is ignored and tmo_flag is never set.
- R6: tmo_flag becomes 1 on the same edge at which a timeout releases cs_hold. It stays 1 until flag_clr is sampled high, and a timeout in the same cycle as flag_clr leaves it set.
- R7: tmo_irq equals tmo_flag AND irq_en, with no delay.
- R8: abort_req sampled high releases cs_hold and zeroes the count at that edge. abort_done is 1 for exactly the cycle after each cycle in which abort_req was high.
- R9: periph_en = 0 releases cs_hold and zeroes the count at the next edge. A later access then restarts the full idle window.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| periph_en | input | 1 | Peripheral enable |
| abort_req | input | 1 | Abort request |
| func_mode | input | 2 | Functional mode; 2'b11 is memory-mapped |
| tmo_en | input | 1 | Idle timeout counter enable |
| tmo_limit | input | 16 | Idle cycles before release |
| access_pulse | input | 1 | One-cycle strobe per memory access |
| flag_clr | input | 1 | Clears the timeout flag |
| irq_en | input | 1 | Timeout interrupt enable |
| cs_hold | output | 1 | Keep chip-select asserted |
| tmo_flag | output | 1 | Sticky timeout flag |
| tmo_irq | output | 1 | Timeout interrupt |
| abort_done | output | 1 | One-cycle abort completion pulse |

## Verification
cs_hold, tmo_flag and abort_done are registered, so each responds to inputs sampled at one edge just after that edge. tmo_irq is combinational from the flag and the enable, so it is valid in the same cycle. The bench drives inputs on the falling edge and advances one rising edge per step. It then samples at the next falling edge, so every expected value refers to exactly one edge. Release timing is counted in idle edges from the access edge: the check one edge before the limit expects the hold, and the check at the limit expects the release together with the flag.

// File: rtl/cst_pkg.sv
package cst_pkg;
  typedef enum logic [1:0] {
    FM_IND_WR  = 2'b00,
    FM_IND_RD  = 2'b01,
    FM_POLL    = 2'b10,
    FM_MEMMAP  = 2'b11
  } fmode_e;

  localparam int unsigned CST_CNT_W = 16;
endpackage

// File: rtl/cst_mode_gate.sv
module cst_mode_gate
  import cst_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       periph_en,
  input  logic       abort_req,
  input  logic [1:0] func_mode,
  output logic       mm_active,
  output logic       kill,
  output logic       abort_done
);
  // Memory-mapped operation needs both the mode and the enable.
  assign mm_active = periph_en && (fmode_e'(func_mode) == FM_MEMMAP);
  // Anything that must drop chip-select and zero the count.
  assign kill      = !mm_active || abort_req;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) abort_done <= 1'b0;
    else        abort_done <= abort_req;
  end
endmodule

// File: rtl/cst_idle_counter.sv
module cst_idle_counter #(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             kill,
  input  logic             access,
  input  logic             tmo_en,
  input  logic [CNT_W-1:0] limit,
  output logic             cs_hold,
  output logic             tmo_event
);
  localparam int unsigned EXT_W = CNT_W + 1;

  logic [CNT_W-1:0] cnt_q;
  logic             reached;

  // True when the next idle edge reaches the limit; a zero limit acts as one.
  function automatic logic idle_reached(input logic [CNT_W-1:0] c,
                                        input logic [CNT_W-1:0] l);
    logic [EXT_W-1:0] nxt;
    nxt = {1'b0, c} + {{CNT_W{1'b0}}, 1'b1};
    return nxt >= {1'b0, l};
  endfunction

  assign reached   = idle_reached(cnt_q, limit);
  assign tmo_event = !kill && !access && cs_hold && tmo_en && reached;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cs_hold <= 1'b0;
      cnt_q   <= '0;
    end else if (kill) begin
      cs_hold <= 1'b0;
      cnt_q   <= '0;
    end else if (access) begin
      cs_hold <= 1'b1;
      cnt_q   <= '0;
    end else if (tmo_event) begin
      cs_hold <= 1'b0;
      cnt_q   <= '0;
    end else if (cs_hold && tmo_en) begin
      cnt_q   <= cnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/cst_event_flag.sv
module cst_event_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic tmo_event,
  input  logic flag_clr,
  input  logic irq_en,
  output logic tmo_flag,
  output logic tmo_irq
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         tmo_flag <= 1'b0;
    else if (tmo_event) tmo_flag <= 1'b1;
    else if (flag_clr)  tmo_flag <= 1'b0;
  end

  assign tmo_irq = tmo_flag & irq_en;
endmodule

// File: rtl/cs_idle_timer.sv
module cs_idle_timer
  import cst_pkg::*;
#(
  parameter int unsigned CNT_W = CST_CNT_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             periph_en,
  input  logic             abort_req,
  input  logic [1:0]       func_mode,
  input  logic             tmo_en,
  input  logic [CNT_W-1:0] tmo_limit,
  input  logic             access_pulse,
  input  logic             flag_clr,
  input  logic             irq_en,
  output logic             cs_hold,
  output logic             tmo_flag,
  output logic             tmo_irq,
  output logic             abort_done
);
  logic mm_active;
  logic kill;
  logic tmo_event;

  cst_mode_gate u_gate (
    .clk        (clk),
    .rst_n      (rst_n),
    .periph_en  (periph_en),
    .abort_req  (abort_req),
    .func_mode  (func_mode),
    .mm_active  (mm_active),
    .kill       (kill),
    .abort_done (abort_done)
  );

  cst_idle_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk       (clk),
    .rst_n     (rst_n),
    .kill      (kill),
    .access    (access_pulse),
    .tmo_en    (tmo_en),
    .limit     (tmo_limit),
    .cs_hold   (cs_hold),
    .tmo_event (tmo_event)
  );

  cst_event_flag u_flag (
    .clk       (clk),
    .rst_n     (rst_n),
    .tmo_event (tmo_event),
    .flag_clr  (flag_clr),
    .irq_en    (irq_en),
    .tmo_flag  (tmo_flag),
    .tmo_irq   (tmo_irq)
  );
endmodule

// File: rtl/cs_idle_timer_chk.sv
module cs_idle_timer_chk (
  input logic clk,
  input logic rst_n,
  input logic abort_req,
  input logic access_pulse,
  input logic flag_clr,
  input logic tmo_en,
  input logic mm_active,
  input logic kill,
  input logic tmo_event,
  input logic cs_hold,
  input logic tmo_flag,
  input logic abort_done
);
  p_access_holds_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (access_pulse && !kill) |=> cs_hold);

  p_timeout_release_r3: assert property (@(posedge clk) disable iff (!rst_n)
    tmo_event |=> (!cs_hold && tmo_flag));

  p_no_count_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_hold && !tmo_en && !kill) |=> cs_hold);

  p_other_mode_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !mm_active |=> !cs_hold);

  p_flag_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (tmo_flag && !flag_clr) |=> tmo_flag);

  p_flag_cause_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tmo_flag) |-> $past(tmo_event));

  p_abort_r8: assert property (@(posedge clk) disable iff (!rst_n)
    abort_req |=> (abort_done && !cs_hold));

  p_release_cause_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cs_hold) |-> $past(kill || tmo_event));
endmodule

bind cs_idle_timer cs_idle_timer_chk u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .abort_req    (abort_req),
  .access_pulse (access_pulse),
  .flag_clr     (flag_clr),
  .tmo_en       (tmo_en),
  .mm_active    (mm_active),
  .kill         (kill),
  .tmo_event    (tmo_event),
  .cs_hold      (cs_hold),
  .tmo_flag     (tmo_flag),
  .abort_done   (abort_done)
);

// File: tb/cs_idle_timer_bench.sv
module cs_idle_timer_bench;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 100000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        periph_en = 1'b0;
  logic        abort_req = 1'b0;
  logic [1:0]  func_mode = 2'b00;
  logic        tmo_en = 1'b0;
  logic [15:0] tmo_limit = 16'd0;
  logic        access_pulse = 1'b0;
  logic        flag_clr = 1'b0;
  logic        irq_en = 1'b0;
  logic        cs_hold, tmo_flag, tmo_irq, abort_done;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  cs_idle_timer u_cs_idle_timer (
    .clk(clk), .rst_n(rst_n), .periph_en(periph_en), .abort_req(abort_req),
    .func_mode(func_mode), .tmo_en(tmo_en), .tmo_limit(tmo_limit),
    .access_pulse(access_pulse), .flag_clr(flag_clr), .irq_en(irq_en),
    .cs_hold(cs_hold), .tmo_flag(tmo_flag), .tmo_irq(tmo_irq),
    .abort_done(abort_done)
  );

  typedef struct packed {
    logic [1:0]  mode;
    logic        en;
    logic        ten;
    logic        ien;
    logic        acc;
    logic        abt;
    logic        clr;
    logic [15:0] lim;
    logic        eh;
    logic        ef;
    logic        ei;
  } vec_t;

  localparam int NVEC = 15;
  // mode en ten ien acc abt clr lim | hold flag irq
  localparam vec_t TBL [NVEC] = '{
    '{2'd3,1'b1,1'b1,1'b1,1'b1,1'b0,1'b0,16'd3, 1'b1,1'b0,1'b0},
    '{2'd3,1'b1,1'b1,1'b1,1'b0,1'b0,1'b0,16'd3, 1'b1,1'b0,1'b0},
    '{2'd3,1'b1,1'b1,1'b1,1'b0,1'b0,1'b0,16'd3, 1'b1,1'b0,1'b0},
    '{2'd3,1'b1,1'b1,1'b1,1'b0,1'b0,1'b0,16'd3, 1'b0,1'b1,1'b1},
    '{2'd3,1'b1,1'b1,1'b1,1'b0,1'b0,1'b0,16'd3, 1'b0,1'b1,1'b1},
    '{2'd3,1'b1,1'b1,1'b1,1'b0,1'b0,1'b1,16'd3, 1'b0,1'b0,1'b0},
    '{2'd3,1'b1,1'b1,1'b1,1'b1,1'b0,1'b0,16'd3, 1'b1,1'b0,1'b0},
    '{2'd3,1'b1,1'b1,1'b1,1'b0,1'b0,1'b0,16'd3, 1'b1,1'b0,1'b0},
    '{2'd3,1'b1,1'b1,1'b1,1'b0,1'b0,1'b0,16'd3, 1'b1,1'b0,1'b0},
    '{2'd3,1'b1,1'b1,1'b1,1'b1,1'b0,1'b0,16'd3, 1'b1,1'b0,1'b0},
    '{2'd3,1'b1,1'b1,1'b1,1'b0,1'b0,1'b0,16'd3, 1'b1,1'b0,1'b0},
    '{2'd3,1'b1,1'b1,1'b1,1'b0,1'b0,1'b0,16'd3, 1'b1,1'b0,1'b0},
    '{2'd3,1'b1,1'b1,1'b1,1'b0,1'b0,1'b0,16'd3, 1'b0,1'b1,1'b1},
    '{2'd3,1'b1,1'b1,1'b0,1'b0,1'b0,1'b1,16'd3, 1'b0,1'b0,1'b0},
    '{2'd1,1'b1,1'b1,1'b1,1'b1,1'b0,1'b0,16'd3, 1'b0,1'b0,1'b0}
  };

  task automatic chk(input string req, input string what,
                     input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%0b expected=%0b", req, what, act, exp);
    end
  endtask

  // Advance one rising edge; return at the following falling edge.
  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic idle_inputs();
    access_pulse = 1'b0;
    abort_req    = 1'b0;
    flag_clr     = 1'b0;
  endtask

  task automatic mm_access(input logic [15:0] lim, input logic ten);
    func_mode = 2'b11; periph_en = 1'b1; tmo_en = ten; tmo_limit = lim;
    access_pulse = 1'b1;
    tick();
    idle_inputs();
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > WATCHDOG) begin
      errors++;
      $display("FAIL watchdog expired after %0d cycles", cycles);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    @(negedge clk);
    // R1 reset state
    chk("R1", "cs_hold in reset", cs_hold, 1'b0);
    chk("R1", "tmo_flag in reset", tmo_flag, 1'b0);
    chk("R1", "tmo_irq in reset", tmo_irq, 1'b0);
    chk("R1", "abort_done in reset", abort_done, 1'b0);
    rst_n = 1'b1;
    tick();
    chk("R1", "cs_hold after reset", cs_hold, 1'b0);

    // Table walk: R2 access/restart, R3 release at limit, R6 flag, R7 irq, R5 mode
    for (int i = 0; i < NVEC; i++) begin
      func_mode = TBL[i].mode; periph_en = TBL[i].en; tmo_en = TBL[i].ten;
      irq_en = TBL[i].ien; access_pulse = TBL[i].acc; abort_req = TBL[i].abt;
      flag_clr = TBL[i].clr; tmo_limit = TBL[i].lim;
      tick();
      chk("R2/R3/R5/R6 table", $sformatf("row %0d cs_hold", i), cs_hold, TBL[i].eh);
      chk("R6 table", $sformatf("row %0d tmo_flag", i), tmo_flag, TBL[i].ef);
      chk("R7 table", $sformatf("row %0d tmo_irq", i), tmo_irq, TBL[i].ei);
    end
    idle_inputs();

    // R3 large limit: held through 999 idle edges, released on the 1000th
    irq_en = 1'b1;
    mm_access(16'd1000, 1'b1);
    for (int k = 0; k < 999; k++) tick();
    chk("R3", "held at limit-1", cs_hold, 1'b1);
    chk("R3", "no flag at limit-1", tmo_flag, 1'b0);
    tick();
    chk("R3", "released at limit", cs_hold, 1'b0);
    chk("R6", "flag with release", tmo_flag, 1'b1);
    flag_clr = 1'b1; tick(); flag_clr = 1'b0;

    // R3 zero limit behaves as one
    mm_access(16'd0, 1'b1);
    chk("R3", "zero limit held after access", cs_hold, 1'b1);
    tick();
    chk("R3", "zero limit released", cs_hold, 1'b0);
    flag_clr = 1'b1; tick(); flag_clr = 1'b0;

    // R4 counter disabled holds forever
    mm_access(16'd2, 1'b0);
    for (int k = 0; k < 50; k++) tick();
    chk("R4", "held with counter off", cs_hold, 1'b1);
    chk("R4", "no flag with counter off", tmo_flag, 1'b0);

    // R8 abort releases, done pulse one cycle
    abort_req = 1'b1;
    tick();
    chk("R8", "abort releases", cs_hold, 1'b0);
    chk("R8", "abort_done pulse", abort_done, 1'b1);
    abort_req = 1'b0;
    tick();
    chk("R8", "abort_done clears", abort_done, 1'b0);

    // R8 abort zeroes the count: full window again afterwards
    mm_access(16'd3, 1'b1);
    tick(); tick();
    abort_req = 1'b1; tick(); abort_req = 1'b0;
    mm_access(16'd3, 1'b1);
    tick(); tick();
    chk("R8", "count zeroed by abort", cs_hold, 1'b1);
    tick();
    chk("R8", "release after full window", cs_hold, 1'b0);
    flag_clr = 1'b1; tick(); flag_clr = 1'b0;

    // R9 peripheral disable releases and zeroes the count
    mm_access(16'd3, 1'b1);
    tick(); tick();
    periph_en = 1'b0;
    tick();
    chk("R9", "disable releases", cs_hold, 1'b0);
    mm_access(16'd3, 1'b1);
    tick(); tick();
    chk("R9", "count zeroed by disable", cs_hold, 1'b1);
    tick();
    chk("R9", "release after full window", cs_hold, 1'b0);

    // R6 timeout wins over clear in the same cycle
    flag_clr = 1'b1; tick(); flag_clr = 1'b0;
    chk("R6", "flag cleared", tmo_flag, 1'b0);
    mm_access(16'd2, 1'b1);
    tick();
    flag_clr = 1'b1;
    tick();
    flag_clr = 1'b0;
    chk("R6", "set wins over clear", tmo_flag, 1'b1);

    // R7 enable gates the interrupt combinationally
    irq_en = 1'b0; #1;
    chk("R7", "irq masked", tmo_irq, 1'b0);
    irq_en = 1'b1; #1;
    chk("R7", "irq unmasked", tmo_irq, 1'b1);

    // R5 polling mode ignores access and never flags
    flag_clr = 1'b1; tick(); flag_clr = 1'b0;
    func_mode = 2'b10; access_pulse = 1'b1; tick(); access_pulse = 1'b0;
    chk("R5", "no hold in polling mode", cs_hold, 1'b0);
    for (int k = 0; k < 5; k++) tick();
    chk("R5", "no flag in polling mode", tmo_flag, 1'b0);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule